// File: doc/BRIEF.md
# Packed Colour Palette Lookup

This block holds a 256-colour lookup table for a display pipeline. Software sees the table as a window of 128 word registers starting at byte offset 0x200. Each 32-bit word packs two 16-bit colour entries, and each entry holds three 5-bit components plus one spare flag bit. Every word is kept exactly as written, so software can read back what it stored, flag bits included.

The pixel side of the block takes an 8-bit colour index. The low bit of the index picks the half of a stored word, and the upper seven bits pick the word. One clock later the block returns the red, green and blue components, each widened to 8 bits, together with a valid flag. The register port and the lookup port run side by side. Each can act in every cycle, and neither stalls the other.

Top module: `palLut`

## Requirements
- R1: A write with `wrEn` high to a byte address in 0x200..0x3FF stores `wrData` into word (addr-0x200)>>2. The address bits [1:0] are ignored.
- R2: A read with `rdEn` high sets `rdValid` on the next cycle. In that cycle `rdData` holds the stored 32-bit word of a window address exactly as written, bits 15 and 31 included.
- R3: A write to an address outside 0x200..0x3FF changes no stored word.
- R4: A read of an address outside 0x200..0x3FF returns zero with `rdValid` high.
- R5: A lookup of index i takes its entry from word i>>1. An even index uses bits 15:0 of that word, and an odd index uses bits 31:16.
- R6: Within an entry, red is bits 4:0, green is bits 9:5 and blue is bits 14:10. Each output is the 5-bit field shifted left by 3, so its low 3 bits are zero.
- R7: Bit 15 of an entry has no effect on the looked-up colour.
- R8: `lkValid` is high in the cycle after a cycle with `lkReq` high, and low in the cycle after a cycle with `lkReq` low.
- R9: When a write and a read or lookup target the same word in the same cycle, the read or lookup returns the contents from before the write.
- R10: While reset is held and right after it, `rdValid`, `lkValid`, `rdData`, `red`, `green` and `blue` are all zero. Table contents are undefined after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 12 | Byte address of the write |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | 12 | Byte address of the read |
| rdData | output | 32 | Read data, one cycle after `rdEn` |
| rdValid | output | 1 | Read data valid |
| lkReq | input | 1 | Lookup request |
| lkIndex | input | 8 | Colour index to look up |
| lkValid | output | 1 | Lookup result valid |
| red | output | 8 | Expanded red component |
| green | output | 8 | Expanded green component |
| blue | output | 8 | Expanded blue component |

## Verification
The whole table is loaded with words whose two halves and flag bits differ. Every word is then read back, and all 256 indices are looked up in turn. This separates a half swap from a field swap and shows whether a flag bit is lost or leaks into the colour. Writes just below and just above the window and at offset zero should alias to words 0 and 127 if the window check is broken, and the later readback of those words exposes that. A write issued in the same cycle as a read and a lookup of the same word shows whether the port returns old or new data. Lookups are issued in bursts with idle gaps to test the valid timing.

// File: rtl/palPkg.sv
package palPkg;
  // Strobes passed from the decode logic to the storage datapath.
  typedef struct packed {
    logic wrStb;   // store a word this cycle
    logic rdStb;   // register read requested
    logic rdHit;   // read address falls inside the window
    logic lkStb;   // lookup requested
    logic lkOdd;   // lookup uses the upper half of the word
  } palStrobes_t;
endpackage

// File: rtl/palCtrl.sv
module palCtrl
  import palPkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int WIN_BASE = 'h200,
  parameter int WORDS    = 128,
  parameter int IDX_W    = 8
) (
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  logic                  lkReq,
  input  logic [IDX_W-1:0]      lkIndex,
  output palStrobes_t           strb,
  output logic [IDX_W-2:0]      wrWord,
  output logic [IDX_W-2:0]      rdWord,
  output logic [IDX_W-2:0]      lkWord
);
  localparam int WIDX_W = IDX_W - 1;
  localparam logic [ADDR_W:0] BASE_L = (ADDR_W+1)'(WIN_BASE);
  localparam logic [ADDR_W:0] END_L  = (ADDR_W+1)'(WIN_BASE + WORDS * 4);

  function automatic logic inWindow(input logic [ADDR_W-1:0] a);
    return ({1'b0, a} >= BASE_L) && ({1'b0, a} < END_L);
  endfunction

  function automatic logic [WIDX_W-1:0] wordOf(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = a - BASE_L[ADDR_W-1:0];
    return off[WIDX_W+1:2];
  endfunction

  always_comb begin
    strb.wrStb = wrEn && inWindow(wrAddr);
    strb.rdStb = rdEn;
    strb.rdHit = inWindow(rdAddr);
    strb.lkStb = lkReq;
    strb.lkOdd = lkIndex[0];
    wrWord     = wordOf(wrAddr);
    rdWord     = wordOf(rdAddr);
    lkWord     = lkIndex[IDX_W-1:1];
  end
endmodule

// File: rtl/palData.sv
module palData
  import palPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORDS  = 128,
  parameter int COMP_W = 5,
  parameter int OUT_W  = 8,
  parameter int WIDX_W = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  palStrobes_t          strb,
  input  logic [WIDX_W-1:0]    wrWord,
  input  logic [WIDX_W-1:0]    rdWord,
  input  logic [WIDX_W-1:0]    lkWord,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdValid,
  output logic                 lkValid,
  output logic [3*OUT_W-1:0]   comps
);
  localparam int HALF_W = DATA_W / 2;
  localparam int PAD_W  = OUT_W - COMP_W;

  logic [DATA_W-1:0] mem [WORDS];
  logic [HALF_W-1:0] halfSel;
  logic [HALF_W-1:0] halfQ;

  // Storage has no reset; contents are undefined until written.
  always_ff @(posedge clk) begin
    if (strb.wrStb) mem[wrWord] <= wrData;
  end

  always_comb begin
    halfSel = strb.lkOdd ? mem[lkWord][DATA_W-1:HALF_W] : mem[lkWord][HALF_W-1:0];
  end

  // Reads sample the array before the same-edge write lands.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
      lkValid <= 1'b0;
      halfQ   <= '0;
    end else begin
      rdValid <= strb.rdStb;
      lkValid <= strb.lkStb;
      if (strb.rdStb) rdData <= strb.rdHit ? mem[rdWord] : '0;
      if (strb.lkStb) halfQ <= halfSel;
    end
  end

  for (genvar c = 0; c < 3; c++) begin : gComp
    assign comps[c*OUT_W +: OUT_W] = {halfQ[c*COMP_W +: COMP_W], {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/palLut.sv
module palLut
  import palPkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int WIN_BASE = 'h200,
  parameter int ENTRIES  = 256,
  parameter int COMP_W   = 5,
  parameter int OUT_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  input  logic              lkReq,
  input  logic [$clog2(ENTRIES)-1:0] lkIndex,
  output logic              lkValid,
  output logic [OUT_W-1:0]  red,
  output logic [OUT_W-1:0]  green,
  output logic [OUT_W-1:0]  blue
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int WORDS  = ENTRIES / 2;
  localparam int WIDX_W = IDX_W - 1;

  palStrobes_t        strb;
  logic [WIDX_W-1:0]  wrWord, rdWord, lkWord;
  logic [3*OUT_W-1:0] comps;

  palCtrl #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WORDS(WORDS), .IDX_W(IDX_W)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .rdEn(rdEn), .rdAddr(rdAddr),
    .lkReq(lkReq), .lkIndex(lkIndex), .strb(strb),
    .wrWord(wrWord), .rdWord(rdWord), .lkWord(lkWord)
  );

  palData #(.DATA_W(DATA_W), .WORDS(WORDS), .COMP_W(COMP_W), .OUT_W(OUT_W), .WIDX_W(WIDX_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrWord(wrWord), .rdWord(rdWord), .lkWord(lkWord), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .lkValid(lkValid), .comps(comps)
  );

  assign red   = comps[0*OUT_W +: OUT_W];
  assign green = comps[1*OUT_W +: OUT_W];
  assign blue  = comps[2*OUT_W +: OUT_W];
endmodule

// File: rtl/palLutChk.sv
module palLutChk #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int WIN_BASE = 'h200,
  parameter int WORDS    = 128,
  parameter int COMP_W   = 5,
  parameter int OUT_W    = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              lkReq,
  input logic              lkValid,
  input logic [OUT_W-1:0]  red,
  input logic [OUT_W-1:0]  green,
  input logic [OUT_W-1:0]  blue
);
  localparam int PAD_W = OUT_W - COMP_W;
  logic rdOutside;
  assign rdOutside = (int'(rdAddr) < WIN_BASE) || (int'(rdAddr) >= WIN_BASE + WORDS * 4);

  // R8
  lk_valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN) lkReq |=> lkValid);
  // R8
  lk_valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN) !lkReq |=> !lkValid);
  // R2
  rd_valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN) rdEn |=> rdValid);
  // R4
  rd_outside_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdOutside) |=> (rdData == '0));
  // R6
  expand_pad_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |-> (red[PAD_W-1:0] == '0 && green[PAD_W-1:0] == '0 && blue[PAD_W-1:0] == '0));
endmodule

bind palLut palLutChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BASE(WIN_BASE),
  .WORDS(ENTRIES / 2), .COMP_W(COMP_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
  .rdValid(rdValid), .lkReq(lkReq), .lkValid(lkValid),
  .red(red), .green(green), .blue(blue)
);

// File: tb/palLut_bench.sv
module palLut_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [11:0] rdAddr = '0;
  logic [31:0] rdData;
  logic        rdValid;
  logic        lkReq = 1'b0;
  logic [7:0]  lkIndex = '0;
  logic        lkValid;
  logic [7:0]  red, green, blue;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] refMem [128];
  bit          expRdV, expLkV;
  logic [31:0] expRd;
  logic [7:0]  expR, expG, expB;

  always #2 clk = ~clk;

  palLut u_palLut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid),
    .lkReq(lkReq), .lkIndex(lkIndex), .lkValid(lkValid),
    .red(red), .green(green), .blue(blue)
  );

  function automatic bit inWin(input int a);
    return a >= 'h200 && a < 'h400;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One clock of the reference model: predict from current inputs, advance, compare.
  task automatic step(input string tag);
    logic [15:0] h;
    expRdV = rdEn;
    expLkV = lkReq;
    if (rdEn) expRd = inWin(int'(rdAddr)) ? refMem[(int'(rdAddr) - 'h200) / 4] : 32'h0;
    if (lkReq) begin
      h = lkIndex[0] ? refMem[lkIndex / 2][31:16] : refMem[lkIndex / 2][15:0];
      expR = {h[4:0], 3'b000};
      expG = {h[9:5], 3'b000};
      expB = {h[14:10], 3'b000};
    end
    if (wrEn && inWin(int'(wrAddr))) refMem[(int'(wrAddr) - 'h200) / 4] = wrData;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "rdValid", {31'b0, rdValid}, {31'b0, expRdV});
    chk(tag, "lkValid", {31'b0, lkValid}, {31'b0, expLkV});
    if (expRdV) chk(tag, "rdData", rdData, expRd);
    if (expLkV) chk(tag, "rgb", {8'h0, red, green, blue}, {8'h0, expR, expG, expB});
    wrEn = 0; rdEn = 0; lkReq = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs quiet under reset
    chk("R10", "rdValid", {31'b0, rdValid}, 32'h0);
    chk("R10", "lkValid", {31'b0, lkValid}, 32'h0);
    chk("R10", "rdData", rdData, 32'h0);
    chk("R10", "rgb", {8'h0, red, green, blue}, 32'h0);
    rstN = 1;
    step("R10");

    // R1: load every word, flag bits set on some
    for (int i = 0; i < 128; i++) begin
      wrEn = 1; wrAddr = 12'(('h200 + i * 4) | (i % 4));
      wrData = (32'(i) * 32'h9E3779B1) ^ ((i % 3 == 0) ? 32'h8000_8000 : 32'h0);
      step("R1");
    end
    // R2: raw readback of every word
    for (int i = 0; i < 128; i++) begin
      rdEn = 1; rdAddr = 12'('h200 + i * 4);
      step("R2");
    end
    // R5 / R6: every index
    for (int i = 0; i < 256; i++) begin
      lkReq = 1; lkIndex = 8'(i);
      step("R5");
    end
    // R6: single-field patterns
    wrEn = 1; wrAddr = 12'h210; wrData = 32'h03E0_001F; step("R6");
    lkReq = 1; lkIndex = 8'd8; step("R6");
    lkReq = 1; lkIndex = 8'd9; step("R6");
    wrEn = 1; wrAddr = 12'h210; wrData = 32'h0000_7C00; step("R6");
    lkReq = 1; lkIndex = 8'd8; step("R6");
    // R7: flag bit toggled, colour must not change
    wrEn = 1; wrAddr = 12'h220; wrData = 32'h8ABC_8ABC; step("R7");
    lkReq = 1; lkIndex = 8'd16; rdEn = 1; rdAddr = 12'h220; step("R7");
    lkReq = 1; lkIndex = 8'd17; step("R7");
    wrEn = 1; wrAddr = 12'h220; wrData = 32'h0ABC_0ABC; step("R7");
    lkReq = 1; lkIndex = 8'd16; step("R7");
    // R3: writes outside window, then read aliased words
    wrEn = 1; wrAddr = 12'h1FC; wrData = 32'hDEAD_BEEF; step("R3");
    wrEn = 1; wrAddr = 12'h400; wrData = 32'hCAFE_F00D; step("R3");
    wrEn = 1; wrAddr = 12'h000; wrData = 32'h1234_5678; step("R3");
    wrEn = 1; wrAddr = 12'hFFC; wrData = 32'h5555_AAAA; step("R3");
    rdEn = 1; rdAddr = 12'h200; step("R3");
    rdEn = 1; rdAddr = 12'h3FC; step("R3");
    lkReq = 1; lkIndex = 8'd255; step("R3");
    // R4: reads outside window
    rdEn = 1; rdAddr = 12'h1FC; step("R4");
    rdEn = 1; rdAddr = 12'h400; step("R4");
    rdEn = 1; rdAddr = 12'hFE0; step("R4");
    // R9: same-word write with read and lookup
    wrEn = 1; wrAddr = 12'h300; wrData = 32'h7FFF_0421;
    rdEn = 1; rdAddr = 12'h300; lkReq = 1; lkIndex = 8'd128; step("R9");
    rdEn = 1; rdAddr = 12'h300; lkReq = 1; lkIndex = 8'd129; step("R9");
    // R8: bursts and gaps
    for (int i = 0; i < 24; i++) begin
      lkReq = (i % 5) < 2; lkIndex = 8'(i * 11);
      rdEn = (i % 3) == 0; rdAddr = 12'('h200 + i * 8);
      step("R8");
    end
    step("R8");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule